// File: doc/BRIEF.md
# Dual-Threshold Thermal Sampling Controller

This block checks a die temperature against two programmable limits while owning only one analog comparator. Software programs two threshold slots and a control word through a small register port. While the controller is running it picks one valid slot and places that slot's threshold code on the DAC output. It then holds the code for a programmable number of clock cycles, so that the DAC and the comparator can settle. At the end of that interval it samples the comparator's single-bit answer. When both slots are valid it alternates between them, one interval each.

Each slot holds its own direction. One direction tests for the temperature being above the code and the other tests for it being below. Each sample records whether the slot's condition holds and marks the result as valid. A level interrupt is raised while any slot with its interrupt enable set reports a valid, met condition. The comparator input means "temperature is above the code now on the DAC".

Top module: `thermal_sampler`

## Requirements
- R1: After synchronous reset every register reads zero, `irq` is low and `dac_code` is zero.
- R2: Address 0 is slot 0, address 1 is slot 1 and address 2 is control. Address 3 reads zero. A slot word has valid at bit 0, interrupt enable at bit 1, direction at bit 2 (1 = below) and the code at bits 9:3. Its status-valid flag is bit 30 and its condition-met flag is bit 31. The control word has the run enable at bit 0 and the 16-bit interval at bits 16:1. All other bits read zero. Read data appears one clock after the address.
- R3: A write to a slot ignores bits 30 and 31 and clears that slot's status-valid and condition-met flags.
- R4: When a slot is selected from idle, its code appears on `dac_code` on the next clock edge. Its status becomes readable as valid exactly one interval later. An interval value of 0 behaves as 1.
- R5: A sample sets condition-met to `cmp_above` for direction 0, and to its inverse for direction 1.
- R6: With both slots valid the controller alternates between them after every sample. A slot whose valid bit is clear is never sampled.
- R7: `irq` is high one cycle after some slot has status-valid, condition-met and interrupt enable all set while run enable is set. With interrupt enable clear the status still updates but `irq` stays low.
- R8: Clearing run enable stops sampling, leaves the status flags unchanged and brings `irq` low on the next edge.
- R9: A write to the slot currently being settled restarts its interval, so its status becomes valid a full interval after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| dac_code | output | 7 | Threshold code of the selected slot |
| cmp_above | input | 1 | Comparator: temperature above `dac_code` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong selection shows on `dac_code` at the edge after it happens, because the code comes straight from the selected slot. A counter that is off by one moves the moment a slot's status turns valid. Reads taken exactly one edge before and one edge after the expected sample cycle expose that shift. A wrong condition or a wrong interrupt-enable decision reaches `irq` one cycle after the status register changes. The bench models the comparator from a temperature value and the live DAC code, so samples taken on the wrong slot also show up as wrong condition flags.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADDR_W  = 2;
  localparam int NUM_THR = 2;

  localparam logic [ADDR_W-1:0] ADDR_THR0 = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_THR1 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // slot word fields (LSB-0)
  localparam int F_VLD  = 0;
  localparam int F_IEN  = 1;
  localparam int F_DIR  = 2;
  localparam int F_CODE = 3;
  // control word fields
  localparam int F_EN   = 0;
  localparam int F_INTV = 1;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_SETTLE = 1'b1} seq_state_t;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs import tsc_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 7,
  parameter int INTV_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                smp_fire,
  input  logic                smp_idx,
  input  logic                smp_met,
  output logic [NUM_THR-1:0]  wr_hit,
  output logic [NUM_THR-1:0]  vld,
  output logic [NUM_THR-1:0]  ien,
  output logic [NUM_THR-1:0]  dir,
  output logic [NUM_THR-1:0]  stv,
  output logic [NUM_THR-1:0]  met,
  output logic [CODE_W-1:0]   code [NUM_THR],
  output logic                ctrl_en,
  output logic [INTV_W-1:0]   intv
);
  localparam int STV_BIT  = DATA_W - 2;
  localparam int MET_BIT  = DATA_W - 1;
  localparam int CTRL_TOP = F_INTV + INTV_W;

  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;
  assign unused_wbits = ^wdata;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_slot
    assign wr_hit[i] = we && (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i]  <= 1'b0;
        ien[i]  <= 1'b0;
        dir[i]  <= 1'b0;
        code[i] <= '0;
        stv[i]  <= 1'b0;
        met[i]  <= 1'b0;
      end else if (wr_hit[i]) begin
        vld[i]  <= wdata[F_VLD];
        ien[i]  <= wdata[F_IEN];
        dir[i]  <= wdata[F_DIR];
        code[i] <= wdata[F_CODE +: CODE_W];
        stv[i]  <= 1'b0;
        met[i]  <= 1'b0;
      end else if (smp_fire && (smp_idx == 1'(i))) begin
        stv[i]  <= 1'b1;
        met[i]  <= smp_met;
      end
    end

    // R3: a write always leaves the slot's status invalid
    a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
      wr_hit[i] |=> (!stv[i] && !met[i]));
    // R4: a sample not overridden by a write validates the status
    a_r4_status_set: assert property (@(posedge clk) disable iff (rst)
      (smp_fire && (smp_idx == 1'(i)) && !wr_hit[i]) |=> stv[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      intv    <= '0;
    end else if (we && (addr == ADDR_CTRL)) begin
      ctrl_en <= wdata[F_EN];
      intv    <= wdata[F_INTV +: INTV_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_THR0, ADDR_THR1: begin
        rd_mux[F_VLD]              = vld[addr[0]];
        rd_mux[F_IEN]              = ien[addr[0]];
        rd_mux[F_DIR]              = dir[addr[0]];
        rd_mux[F_CODE +: CODE_W]   = code[addr[0]];
        rd_mux[STV_BIT]            = stv[addr[0]];
        rd_mux[MET_BIT]            = met[addr[0]];
      end
      ADDR_CTRL: begin
        rd_mux[F_EN]               = ctrl_en;
        rd_mux[F_INTV +: INTV_W]   = intv;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R2: reserved control bits read as zero
  a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_CTRL) |=> (rdata[DATA_W-1:CTRL_TOP] == '0));
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq import tsc_pkg::*; #(
  parameter int INTV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [INTV_W-1:0]  intv,
  input  logic [NUM_THR-1:0] vld,
  input  logic [NUM_THR-1:0] dir,
  input  logic [NUM_THR-1:0] wr_hit,
  input  logic               cmp_above,
  output logic               sel,
  output logic               settling,
  output logic               smp_fire,
  output logic               smp_met
);
  seq_state_t        state;
  logic [INTV_W-1:0] cnt;
  logic [INTV_W-1:0] load_val;
  logic              active;
  logic              other;

  assign other    = ~sel;
  assign active   = en && (|vld);
  assign load_val = (intv == '0) ? INTV_W'(1) : intv;
  assign settling = (state == SQ_SETTLE);
  assign smp_fire = active && settling && vld[sel] && !wr_hit[sel]
                    && (cnt == INTV_W'(1));
  assign smp_met  = dir[sel] ? ~cmp_above : cmp_above;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      sel   <= 1'b0;
      cnt   <= '0;
    end else if (!active) begin
      state <= SQ_IDLE;
    end else if (state == SQ_IDLE) begin
      state <= SQ_SETTLE;
      sel   <= vld[0] ? 1'b0 : 1'b1;
      cnt   <= load_val;
    end else if (!vld[sel]) begin
      sel   <= other;
      cnt   <= load_val;
    end else if (wr_hit[sel]) begin
      cnt   <= load_val;
    end else if (smp_fire) begin
      if (vld[other]) sel <= other;
      cnt   <= load_val;
    end else begin
      cnt   <= cnt - INTV_W'(1);
    end
  end

  // R6: with both slots valid, every sample hands over to the other slot
  a_r6_alternate: assert property (@(posedge clk) disable iff (rst)
    (smp_fire && (&vld) && !(|wr_hit)) |=> (sel != $past(sel)));
  // R9: a write to the settling slot postpones its sample
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    (settling && active && wr_hit[sel] && (intv > INTV_W'(1))) |=> !smp_fire);
  // R8: dropping run enable returns to idle
  a_r8_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |=> !settling);
endmodule

// File: rtl/thermal_sampler.sv
module thermal_sampler import tsc_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 7,
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CODE_W-1:0] dac_code,
  input  logic              cmp_above,
  output logic              irq
);
  logic [NUM_THR-1:0] wr_hit, vld, ien, dir, stv, met;
  logic [CODE_W-1:0]  code [NUM_THR];
  logic               ctrl_en;
  logic [INTV_W-1:0]  intv;
  logic               sel, settling, smp_fire, smp_met;

  tsc_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .INTV_W(INTV_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .smp_fire(smp_fire), .smp_idx(sel), .smp_met(smp_met),
    .wr_hit(wr_hit), .vld(vld), .ien(ien), .dir(dir), .stv(stv), .met(met),
    .code(code), .ctrl_en(ctrl_en), .intv(intv)
  );

  tsc_seq #(.INTV_W(INTV_W)) u_seq (
    .clk(clk), .rst(rst), .en(ctrl_en), .intv(intv), .vld(vld), .dir(dir),
    .wr_hit(wr_hit), .cmp_above(cmp_above), .sel(sel), .settling(settling),
    .smp_fire(smp_fire), .smp_met(smp_met)
  );

  assign dac_code = code[sel];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl_en && (|(stv & met & ien));
  end

  // R8: no interrupt while the run enable is clear
  a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq);
  // R4: the DAC code holds steady through a settle interval
  a_r4_dac_hold: assert property (@(posedge clk) disable iff (rst)
    (settling && $past(settling) && !$past(smp_fire) && !$past(|wr_hit))
      |-> $stable(dac_code));
endmodule

// File: tb/tb_thermal_sampler.sv
module tb_thermal_sampler;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [6:0]  dac_code;
  logic        cmp_above;
  logic        irq;
  int          temp = 0;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 dac code
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t q[$];

  thermal_sampler dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dac_code(dac_code),
    .cmp_above(cmp_above), .irq(irq)
  );

  // comparator model: temperature above the code on the DAC
  assign cmp_above = (temp > int'(dac_code));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items once their cycle has come
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = reg_rdata;
          1:       act = {31'b0, irq};
          default: act = {25'b0, dac_code};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    q.push_back('{0, e, cyc + 1, tag});
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    q.push_back('{1, {31'b0, e}, cyc + 1, tag});
  endtask

  task automatic exp_dac(input logic [6:0] e, input string tag);
    q.push_back('{2, {25'b0, e}, cyc + 1, tag});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dchk(input bit ok, input string tag, input int act, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen_a, seen_b, seen_x;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    exp_irq(1'b0, "R1 irq after reset");
    exp_dac(7'd0, "R1 dac after reset");
    rd(2'd0, 32'h0, "R1 slot0 reset");
    rd(2'd1, 32'h0, "R1 slot1 reset");
    rd(2'd2, 32'h0, "R1 ctrl reset");

    // R2 / R3 layout, reserved bits, read-only status
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_03FF, "R3 status bits ignored on write");
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, 32'h0001_FFFE, "R2 ctrl fields and reserved zero");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R2 unused address");

    // R4 settle timing, interval 5, slot0 above 20
    wr(2'd0, 32'h0000_00A3);
    wr(2'd1, 32'h0);
    temp = 40;
    wr(2'd2, 32'h0000_000B);
    exp_dac(7'd20, "R4 code on dac after selection");
    idle(5);
    exp_irq(1'b0, "R7 no irq before sample");
    rd(2'd0, 32'h0000_00A3, "R4 status not yet valid");
    rd(2'd0, 32'hC000_00A3, "R4 status valid after interval");
    exp_irq(1'b1, "R7 irq follows met status");
    rd(2'd1, 32'h0, "R6 invalid slot never sampled");

    // R5 above condition false
    temp = 10;
    idle(15);
    rd(2'd0, 32'h4000_00A3, "R5 above condition false");
    exp_irq(1'b0, "R7 irq drops with condition");

    // R5/R6 slot1 below 50, both valid
    wr(2'd1, 32'h0000_0197);
    idle(30);
    rd(2'd1, 32'hC000_0197, "R5 below condition true");
    rd(2'd0, 32'h4000_00A3, "R6 slot0 still sampled");
    exp_irq(1'b1, "R7 irq from slot1");

    // R6 alternation visible on the DAC
    seen_a = 1'b0; seen_b = 1'b0; seen_x = 1'b0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (dac_code == 7'd20) seen_a = 1'b1;
      else if (dac_code == 7'd50) seen_b = 1'b1;
      else seen_x = 1'b1;
    end
    dchk(seen_a && seen_b && !seen_x, "R6 dac alternates 20/50",
         {29'b0, seen_x, seen_b, seen_a}, 3);

    // R7 interrupt enable clear
    wr(2'd0, 32'h0000_00A1);
    wr(2'd1, 32'h0000_0195);
    temp = 30;
    idle(30);
    rd(2'd0, 32'hC000_00A1, "R7 slot0 updates without ien");
    rd(2'd1, 32'hC000_0195, "R7 slot1 updates without ien");
    exp_irq(1'b0, "R7 no irq with ien clear");

    // R9 restart on write to settling slot, interval 8
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0000_0011);
    temp = 40;
    idle(20);
    wr(2'd0, 32'h0000_00A3);
    idle(7);
    rd(2'd0, 32'h0000_00A3, "R9 not valid before full interval");
    rd(2'd0, 32'hC000_00A3, "R9 valid after full interval");

    // R4 interval 0 acts as 1
    wr(2'd2, 32'h0000_0001);
    idle(3);
    wr(2'd0, 32'h0000_00A3);
    rd(2'd0, 32'h0000_00A3, "R4 zero interval before sample");
    rd(2'd0, 32'hC000_00A3, "R4 zero interval sampled after one");

    // R8 disable
    idle(4);
    exp_irq(1'b1, "R8 irq before disable");
    wr(2'd2, 32'h0);
    exp_irq(1'b0, "R8 irq low after disable");
    temp = 5;
    idle(20);
    rd(2'd0, 32'hC000_00A3, "R8 status held while stopped");
    rd(2'd2, 32'h0, "R8 ctrl cleared");
    exp_irq(1'b0, "R8 irq stays low");

    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule